// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block sits between a processor request port and a main-memory port that moves one whole line at a time. It keeps a small direct-mapped array of lines. Each line has a valid flag, a dirty flag, a tag and its data. Every processor address is split into a tag, a line index and a byte offset. A lookup compares the stored tag of the indexed line against the address tag. On a miss the processor is held off with a stall signal. If the victim line is dirty, its contents are first written back to memory. The wanted block is then fetched, and the access is replayed against the refreshed line.

Two build-time parameters choose the write policy, which gives four combinations. The first selects whether a write miss allocates a line. The second selects whether writes stay in the cache until eviction (write-back) or are forwarded to memory at once (write-through). Writes carry one byte. Reads return the 32-bit word that holds the addressed byte.

The memory side uses a request/ready handshake. A read request fetches a full line. A write request carries a full line plus per-byte strobes, so a single-byte write-through needs no read-modify-write.

Top module: `dm_cache_ctrl`

## Requirements
- R1: An address splits as follows. Byte offset is bits [OFF_W-1:0]. Line index is bits [OFF_W+IDX_W-1:OFF_W]. Tag is the remaining upper bits. The memory block address is the address shifted right by OFF_W. Word select is bits [OFF_W-1:2], and byte k of the selected word sits in bits [8k+7:8k].
- R2: After reset every line is invalid, so the first access to any line misses. The memory request and the stall are low while no access is pending.
- R3: A read hit returns the selected word on the cycle after the request is seen, with no memory transaction.
- R4: On a read miss in write-back mode, the controller first writes back a valid dirty victim, with all strobes set, to block {old tag, index}. It then reads the requested block, marks the line valid and clean with the new tag, and retries the access. The returned word is correct.
- R5: In write-back mode, a write hit updates only the addressed byte in the cache and marks the line dirty, with no memory transaction.
- R6: In write-through mode, a write hit updates the cache byte and issues one memory write whose strobe has only the addressed byte set.
- R7: With write-allocate, a write miss refills the line (after a dirty write-back in write-back mode) and then performs the write under the selected policy.
- R8: With no-write-allocate, a write miss issues one single-strobe memory write and leaves the cached line unchanged.
- R9: In write-through mode, no line becomes dirty, so no line write-back ever occurs.
- R10: Once raised, a memory request holds its command and address stable until ready is seen.
- R11: The stall is high from a pending request until the cycle the access completes. It is never high while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until stall is low |
| cpu_we | input | 1 | 1 = byte write, 0 = word read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wbyte | input | 8 | Write data byte |
| cpu_rdata | output | 32 | Read word, valid when the request completes |
| cpu_stall | output | 1 | Request not yet complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Memory block address |
| mem_wdata | output | 8<<OFF_W | Line write data |
| mem_wstrb | output | 1<<OFF_W | Per-byte write enables |
| mem_rdata | input | 8<<OFF_W | Line read data |
| mem_ready | input | 1 | Transaction completes this cycle |

## Verification
The same access script runs against all four policy combinations. The script has three parts:
- A full word-read sweep of the address space separates compulsory misses from the hits on the second word of each line.
- A scattered byte-write pass lands on both cached and uncached lines. It separates allocate from non-allocate and write-back from write-through, through the count of memory reads and writes and the memory byte after each write.
- A ping-pong between two addresses that share an index forces repeated dirty evictions. This shows that the victim goes to its old block and that the data read back stays coherent.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RETRY,
    ST_THROUGH
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
`timescale 1ns/1ps
module dmc_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (idx == IDX_W'(i)) begin
        if (fill_en) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
        end else if (dirty_set) begin
          dirty_q[i] <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && idx == IDX_W'(i)) tag_q[i] <= fill_tag;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/dmc_data_store.sv
`timescale 1ns/1ps
module dmc_data_store #(
  parameter int IDX_W = 2,
  parameter int OFF_W = 3
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  output logic [(8<<OFF_W)-1:0]  rd_line,
  input  logic                   fill_en,
  input  logic [(8<<OFF_W)-1:0]  fill_line,
  input  logic                   byte_en,
  input  logic [OFF_W-1:0]       byte_sel,
  input  logic [7:0]             byte_val
);
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = 8 << OFF_W;

  logic [LINE_W-1:0] line_q [LINES];

  always_ff @(posedge clk) begin
    if (fill_en)      line_q[idx] <= fill_line;
    else if (byte_en) line_q[idx][byte_sel*8 +: 8] <= byte_val;
  end

  assign rd_line = line_q[idx];
endmodule

// File: rtl/dm_cache_ctrl.sv
`timescale 1ns/1ps
module dm_cache_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 2,
  parameter int OFF_W       = 3,
  parameter bit WRITE_ALLOC = 1'b1,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [7:0]                cpu_wbyte,
  output logic [31:0]               cpu_rdata,
  output logic                      cpu_stall,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-OFF_W-1:0]   mem_addr,
  output logic [(8<<OFF_W)-1:0]     mem_wdata,
  output logic [(1<<OFF_W)-1:0]     mem_wstrb,
  input  logic [(8<<OFF_W)-1:0]     mem_rdata,
  input  logic                      mem_ready
);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W      = ADDR_W - OFF_W;
  localparam int LINE_BYTES = 1 << OFF_W;
  localparam int LINE_W     = 8 * LINE_BYTES;
  localparam int WSEL_W     = OFF_W - 2;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                input logic [ADDR_W-1:0] a);
    logic [WSEL_W-1:0] sel;
    sel = a[OFF_W-1:2];
    return line[sel*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_BYTES-1:0] strobe_of(input logic [ADDR_W-1:0] a);
    return LINE_BYTES'(1) << a[OFF_W-1:0];
  endfunction

  dmc_state_e state_q, state_d;

  logic             line_valid, line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic [LINE_W-1:0] line_data;

  // Named internal events, observed by the bound checker
  logic lookup_hit;
  logic lookup_miss;
  logic fill_done;
  logic access_done;
  logic byte_wr;

  wire [IDX_W-1:0] cur_idx = idx_of(cpu_addr);
  wire [TAG_W-1:0] cur_tag = tag_of(cpu_addr);

  assign lookup_hit  = (state_q == ST_COMPARE) && line_valid && (line_tag == cur_tag);
  assign lookup_miss = (state_q == ST_COMPARE) && !(line_valid && (line_tag == cur_tag));
  assign fill_done   = (state_q == ST_REFILL) && mem_ready;
  assign byte_wr     = lookup_hit && cpu_we;
  assign access_done = (lookup_hit && (!cpu_we || WRITE_BACK)) ||
                       ((state_q == ST_THROUGH) && mem_ready);

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (cur_idx),
    .rd_valid  (line_valid),
    .rd_dirty  (line_dirty),
    .rd_tag    (line_tag),
    .fill_en   (fill_done),
    .fill_tag  (cur_tag),
    .dirty_set (byte_wr && WRITE_BACK)
  );

  dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk       (clk),
    .idx       (cur_idx),
    .rd_line   (line_data),
    .fill_en   (fill_done),
    .fill_line (mem_rdata),
    .byte_en   (byte_wr),
    .byte_sel  (cpu_addr[OFF_W-1:0]),
    .byte_val  (cpu_wbyte)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (lookup_hit) begin
          state_d = (cpu_we && !WRITE_BACK) ? ST_THROUGH : ST_IDLE;
        end else if (cpu_we && !WRITE_ALLOC) begin
          state_d = ST_THROUGH;
        end else if (WRITE_BACK && line_valid && line_dirty) begin
          state_d = ST_WRITEBACK;
        end else begin
          state_d = ST_REFILL;
        end
      end
      ST_WRITEBACK: if (mem_ready) state_d = ST_REFILL;
      ST_REFILL:    if (mem_ready) state_d = ST_RETRY;
      ST_RETRY:     state_d = ST_COMPARE;
      ST_THROUGH:   if (mem_ready) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  wire evict = (state_q == ST_WRITEBACK);

  assign mem_req   = evict || (state_q == ST_REFILL) || (state_q == ST_THROUGH);
  assign mem_we    = (state_q != ST_REFILL);
  assign mem_addr  = evict ? {line_tag, cur_idx} : blk_of(cpu_addr);
  assign mem_wdata = evict ? line_data : {LINE_BYTES{cpu_wbyte}};
  assign mem_wstrb = evict ? {LINE_BYTES{1'b1}} : strobe_of(cpu_addr);

  assign cpu_rdata = word_of(line_data, cpu_addr);
  assign cpu_stall = cpu_req && !access_done;
endmodule

// File: rtl/dm_cache_ctrl_chk.sv
`timescale 1ns/1ps
module dm_cache_ctrl_chk #(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 2,
  parameter int OFF_W       = 3,
  parameter bit WRITE_ALLOC = 1'b1,
  parameter bit WRITE_BACK  = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req,
  input logic                    cpu_we,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic                    cpu_stall,
  input logic                    mem_req,
  input logic                    mem_we,
  input logic [ADDR_W-OFF_W-1:0] mem_addr,
  input logic [(1<<OFF_W)-1:0]   mem_wstrb,
  input logic                    mem_ready,
  input logic                    lookup_hit,
  input logic                    fill_done
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R11
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |-> cpu_stall);

  // R11
  quiet_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall);

  // R4
  victim_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (&mem_wstrb) |->
      mem_addr[IDX_W-1:0] == cpu_addr[OFF_W +: IDX_W] &&
      mem_addr != cpu_addr[ADDR_W-1:OFF_W]);

  // R4
  retry_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> ##2 lookup_hit);

  // R1
  fill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr == cpu_addr[ADDR_W-1:OFF_W]);

  if (!WRITE_BACK) begin : g_wt
    // R9
    wt_single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> $countones(mem_wstrb) == 1);
  end

  if (!WRITE_ALLOC) begin : g_nwa
    // R8
    nwa_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> !cpu_we);
  end
endmodule

bind dm_cache_ctrl dm_cache_ctrl_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
  .WRITE_ALLOC(WRITE_ALLOC), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
  .mem_ready(mem_ready), .lookup_hit(lookup_hit), .fill_done(fill_done)
);

// File: tb/dmc_harness.sv
`timescale 1ns/1ps
module dmc_harness #(
  parameter bit WA = 1'b1,
  parameter bit WB = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   pass_n,
  output int   fail_n
);
  logic        cpu_req, cpu_we, cpu_stall;
  logic [7:0]  cpu_addr, cpu_wbyte;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [4:0]  mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [7:0]  mem_wstrb;

  dm_cache_ctrl #(.ADDR_W(8), .IDX_W(2), .OFF_W(3),
                  .WRITE_ALLOC(WA), .WRITE_BACK(WB)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wbyte(cpu_wbyte), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  // Memory model: ready two cycles after the request rises
  logic [63:0] mem [32];
  int lat, rd_n, wr_n;

  assign mem_ready = mem_req && (lat == 2);
  assign mem_rdata = mem[mem_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat  <= 0;
      rd_n <= 0;
      wr_n <= 0;
      for (int k = 0; k < 32; k++)
        for (int j = 0; j < 8; j++) mem[k][j*8 +: 8] <= pat(k*8 + j);
    end else if (mem_ready) begin
      lat <= 0;
      if (mem_we) begin
        wr_n <= wr_n + 1;
        for (int j = 0; j < 8; j++)
          if (mem_wstrb[j]) mem[mem_addr][j*8 +: 8] <= mem_wdata[j*8 +: 8];
      end else begin
        rd_n <= rd_n + 1;
      end
    end else if (mem_req) lat <= lat + 1;
    else lat <= 0;
  end

  // Bench reference state
  logic [7:0] gold [256];
  logic [3:0] mv, md;
  logic [2:0] mt [4];
  string pol;

  function automatic logic [7:0] membyte(input logic [7:0] a);
    return mem[a[7:3]][a[2:0]*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s %s actual=%0h expected=%0h", pol, rq, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [7:0] addr, input logic [7:0] b,
                        input string ph);
    int idx, erd, ewr, r0, w0, n;
    logic [2:0] tg;
    bit hit, vict;
    logic [7:0] oldb, wa;
    logic [31:0] got, expw;
    string rq;
    idx  = int'(addr[4:3]);
    tg   = addr[7:5];
    hit  = mv[idx] && mt[idx] == tg;
    vict = WB && mv[idx] && md[idx];
    erd = 0; ewr = 0;
    if (!we) begin
      rq = hit ? "R3" : (WB ? "R4" : "R9");
      if (!hit) begin erd = 1; ewr = vict; mv[idx] = 1'b1; mt[idx] = tg; md[idx] = 1'b0; end
    end else if (hit) begin
      rq = WB ? "R5" : "R6";
      if (WB) md[idx] = 1'b1; else ewr = 1;
    end else if (WA) begin
      rq = "R7";
      erd = 1; ewr = vict + (WB ? 0 : 1);
      mv[idx] = 1'b1; mt[idx] = tg; md[idx] = WB;
    end else begin
      rq = "R8";
      ewr = 1;
    end
    rq = {rq, " ", ph};
    oldb = membyte(addr);
    if (we) gold[addr] = b;
    wa   = addr & 8'hFC;
    expw = {gold[wa+3], gold[wa+2], gold[wa+1], gold[wa]};
    r0 = rd_n; w0 = wr_n;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wbyte = b;
    n = 0;
    do begin @(negedge clk); n++; end while (cpu_stall && n < 100);
    got = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(n < 100, {"R11 completion ", rq}, 64'(n), 64'd100);
    if (!we) chk(got == expw, {"rdata ", rq}, 64'(got), 64'(expw));
    chk(rd_n - r0 == erd, {"mem reads ", rq}, 64'(rd_n - r0), 64'(erd));
    chk(wr_n - w0 == ewr, {"mem writes ", rq}, 64'(wr_n - w0), 64'(ewr));
    if (hit && (!we || WB)) chk(n == 1, {"hit latency ", rq}, 64'(n), 64'd1);
    if (we) begin
      if (hit && WB) chk(membyte(addr) == oldb, {"mem untouched ", rq}, 64'(membyte(addr)), 64'(oldb));
      else if (!WB || !WA || !hit)
        if (!WB || !hit) chk(membyte(addr) == (WB && WA ? oldb : b), {"mem byte ", rq},
                             64'(membyte(addr)), 64'(WB && WA ? oldb : b));
    end
  endtask

  initial begin
    pol = $sformatf("[alloc=%0d back=%0d]", WA, WB);
    done = 1'b0; pass_n = 0; fail_n = 0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wbyte = '0;
    mv = '0; md = '0;
    for (int i = 0; i < 4; i++) mt[i] = '0;
    for (int a = 0; a < 256; a++) gold[a] = pat(a);
    wait (rst_n === 1'b1);
    @(negedge clk);
    // R2: idle outputs after reset
    chk(cpu_stall == 1'b0, "R2 stall after reset", 64'(cpu_stall), 64'd0);
    chk(mem_req == 1'b0, "R2 mem_req after reset", 64'(mem_req), 64'd0);
    // Word-read sweep: first word of each line misses (R2), second hits
    for (int i = 0; i < 64; i++) access(1'b0, 8'(i*4), 8'h00, "sweep1 R1 R2");
    // Scattered byte writes
    for (int i = 0; i < 48; i++) access(1'b1, 8'(i*37 + 5), 8'(i*11) ^ 8'h3C, "scatter");
    // Second read sweep checks coherence after writes and evictions
    for (int i = 0; i < 64; i++) access(1'b0, 8'(i*4), 8'h00, "sweep2");
    // R1: 0x11 and 0x31 share index 2 with tags 0 and 1
    for (int i = 0; i < 8; i++) begin
      access(1'b1, 8'h11, 8'(8'hA0 + i), "pingpong R1");
      access(1'b0, 8'h31, 8'h00, "pingpong R1");
      access(1'b0, 8'h10, 8'h00, "pingpong R1");
    end
    done = 1'b1;
  end
endmodule

// File: tb/dm_cache_ctrl_test.sv
`timescale 1ns/1ps
module dm_cache_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic d0, d1, d2, d3;
  int p0, p1, p2, p3, f0, f1, f2, f3;

  dmc_harness #(.WA(1'b1), .WB(1'b1)) h_alloc_back    (.clk(clk), .rst_n(rst_n), .done(d0), .pass_n(p0), .fail_n(f0));
  dmc_harness #(.WA(1'b1), .WB(1'b0)) h_alloc_through (.clk(clk), .rst_n(rst_n), .done(d1), .pass_n(p1), .fail_n(f1));
  dmc_harness #(.WA(1'b0), .WB(1'b1)) h_noalloc_back  (.clk(clk), .rst_n(rst_n), .done(d2), .pass_n(p2), .fail_n(f2));
  dmc_harness #(.WA(1'b0), .WB(1'b0)) h_noalloc_thru  (.clk(clk), .rst_n(rst_n), .done(d3), .pass_n(p3), .fail_n(f3));

  initial begin
    int cycles;
    int wd_fail;
    wd_fail = 0;
    cycles = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(d0 && d1 && d2 && d3) && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(d0 && d1 && d2 && d3)) begin
      wd_fail = 1;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<150000", cycles);
    end
    $display("%0d/%0d checks passed", p0 + p1 + p2 + p3,
             p0 + p1 + p2 + p3 + f0 + f1 + f2 + f3 + wd_fail);
    $finish;
  end
endmodule